// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers 32 interrupt request lines, latches each rising request into a pending bit, and presents the single most urgent request to a processor core as a registered interrupt number with a valid flag. Software reaches it through a simple word-wide register bus. Enable state and pending state each have their own set address and clear address. Eight priority registers hold a 2-bit urgency level for every line.

The winner is the line that is both pending and enabled and has the smallest level value. Level 0 is the most urgent and level 3 the least. When several lines share the best level, the lowest line number wins. The core acknowledges an interrupt by returning its number. That clears the pending bit so the next candidate can be presented.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0x00000000 and `irq_valid` is 0.
- R2: Bit i of the enable-set register (offset 0x100) and of the enable-clear register (offset 0x180) maps to line i. Writing 1 to a bit sets or clears that line's enable. Writing 0 changes nothing. A read of either offset returns the current enable vector.
- R3: The pending-set register (offset 0x200) and the pending-clear register (offset 0x280) act on the pending vector in the same way as R2, and a read of either returns it.
- R4: Priority register n sits at offset 0x400 + 4n, for n = 0 to 7. Line 4n+k keeps its level in bits [8k+7:8k+6], so the data is little-endian by byte lane. All other bits read as 0 and ignore writes.
- R5: An access whose `bus_size` is not 2'b10 (word) raises `bus_err` in the same cycle. It updates no register, and such a read returns 0. A word access never raises `bus_err`.
- R6: A 0-to-1 change on `irq_in[i]` sets pending bit i at the next clock edge. A line held high does not set the bit again after it has been cleared.
- R7: Among the lines that are pending and enabled, the line with the lowest level value is chosen. Equal levels are resolved in favour of the lowest line number. Lines that are not enabled are never chosen.
- R8: `irq_id` and `irq_valid` are registered. They show the selection made from the pending, enable and level state of the previous cycle. `irq_valid` is 0 when no line is both pending and enabled.
- R9: `core_ack` with `core_ack_id` clears that pending bit at the next clock edge. If the same bit is set in that cycle by an input edge or a pending-set write, the set takes precedence.
- R10: Read data is combinational in the cycle in which `bus_sel` is high and `bus_wr` is low. Unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Access size error |
| irq_in | input | 32 | Interrupt request lines |
| core_ack | input | 1 | Core acknowledges an interrupt |
| core_ack_id | input | 5 | Number of the acknowledged line |
| irq_valid | output | 1 | A request is being presented |
| irq_id | output | 5 | Number of the presented line |

## Verification
Register reads and `bus_err` are combinational, so the bench checks them shortly after driving the access, within the same cycle. A register write, an input edge or an acknowledge takes effect at the next clock edge, and the bench reads the register back in the following cycle. The presented interrupt trails that state change by one more edge. After each stimulus, the bench first checks that the output still shows the old selection and then checks the new one a cycle later, which pins the single-cycle lag of R8.

// File: rtl/irq_prio_pkg.sv
// Shared definitions for the prioritized interrupt controller.
// Assumes a 12-bit byte offset bus and at most 32 interrupt lines.
package irq_prio_pkg;

    localparam logic [11:0] OFS_EN_SET   = 12'h100;
    localparam logic [11:0] OFS_EN_CLR   = 12'h180;
    localparam logic [11:0] OFS_PEND_SET = 12'h200;
    localparam logic [11:0] OFS_PEND_CLR = 12'h280;
    localparam logic [11:0] OFS_LVL_BASE = 12'h400;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } bus_size_e;

endpackage

// File: rtl/irq_edge_det.sv
// Rising-edge detector for the interrupt request lines.
// Produces a one-cycle pulse per line when the line goes from 0 to 1.
// Assumes the inputs are already synchronous to clk.
module irq_edge_det #(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] lines_i,
    output logic [NUM_IRQ-1:0] rise_o
);

    logic [NUM_IRQ-1:0] prev_q;

    // Remember the previous level of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines_i;
    end

    assign rise_o = lines_i & ~prev_q;

endmodule

// File: rtl/irq_reg_file.sv
// Register file of the interrupt controller: enable, pending and level state.
// It decodes word-only bus accesses and merges input edges and core
// acknowledges into the pending vector. Assumes NUM_IRQ is a multiple of 4
// and no larger than 32.
module irq_reg_file
    import irq_prio_pkg::*;
#(
    parameter int NUM_IRQ   = 32,
    parameter int PRIO_BITS = 2,
    parameter int ADDR_W    = 12,
    localparam int ID_W     = $clog2(NUM_IRQ),
    localparam int NUM_LREG = NUM_IRQ / 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [1:0]                   bus_size,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    output logic                         bus_err,
    input  logic [NUM_IRQ-1:0]           rise_i,
    input  logic                         ack_i,
    input  logic [ID_W-1:0]              ack_id_i,
    output logic [NUM_IRQ-1:0]           en_o,
    output logic [NUM_IRQ-1:0]           pend_o,
    output logic [NUM_IRQ*PRIO_BITS-1:0] lvl_o
);

    localparam logic [ADDR_W-1:0] LVL_END = ADDR_W'(OFS_LVL_BASE) + ADDR_W'(4 * NUM_LREG);

    logic                    word_ok;
    logic                    wr_ok;
    logic                    hit_en_set, hit_en_clr, hit_pd_set, hit_pd_clr, hit_lvl;
    logic [ADDR_W-1:0]       lvl_ofs;
    logic [ADDR_W-3:0]       lvl_idx;
    logic [NUM_IRQ-1:0]      en_q, pend_q;
    logic [NUM_IRQ-1:0]      set_vec, clr_vec;
    logic [PRIO_BITS-1:0]    lvl_q [NUM_IRQ];

    // Address decode; only word-sized accesses are legal.
    assign word_ok    = (bus_size == SZ_WORD);
    assign wr_ok      = bus_sel && bus_wr && word_ok;
    assign hit_en_set = (bus_addr == ADDR_W'(OFS_EN_SET));
    assign hit_en_clr = (bus_addr == ADDR_W'(OFS_EN_CLR));
    assign hit_pd_set = (bus_addr == ADDR_W'(OFS_PEND_SET));
    assign hit_pd_clr = (bus_addr == ADDR_W'(OFS_PEND_CLR));
    assign hit_lvl    = (bus_addr >= ADDR_W'(OFS_LVL_BASE)) && (bus_addr < LVL_END)
                        && (bus_addr[1:0] == 2'b00);
    assign lvl_ofs    = bus_addr - ADDR_W'(OFS_LVL_BASE);
    assign lvl_idx    = lvl_ofs[ADDR_W-1:2];
    assign bus_err    = bus_sel && !word_ok;

    // Enable vector: separate set and clear addresses, ones act.
    always_ff @(posedge clk) begin
        if (!rst_n)                   en_q <= '0;
        else if (wr_ok && hit_en_set) en_q <= en_q | bus_wdata[NUM_IRQ-1:0];
        else if (wr_ok && hit_en_clr) en_q <= en_q & ~bus_wdata[NUM_IRQ-1:0];
    end

    // Collect pending set and clear requests of this cycle.
    always_comb begin
        set_vec = rise_i;
        clr_vec = '0;
        if (wr_ok && hit_pd_set) set_vec = set_vec | bus_wdata[NUM_IRQ-1:0];
        if (wr_ok && hit_pd_clr) clr_vec = bus_wdata[NUM_IRQ-1:0];
        if (ack_i)               clr_vec[ack_id_i] = 1'b1;
    end

    // Pending vector: a set in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_vec) | set_vec;
    end

    // One level field per line, taken from the top bits of its byte lane.
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_lvl
        localparam int REG_N = i / 4;
        localparam int LANE  = i % 4;
        // Capture this line's level on a word write to its register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_q[i] <= '0;
            else if (wr_ok && hit_lvl && (int'(lvl_idx) == REG_N))
                lvl_q[i] <= bus_wdata[8*LANE+7 -: PRIO_BITS];
        end
        assign lvl_o[i*PRIO_BITS +: PRIO_BITS] = lvl_q[i];
    end

    // Read multiplexer; sub-word or unmapped reads return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && word_ok) begin
            if (hit_en_set || hit_en_clr)
                bus_rdata[NUM_IRQ-1:0] = en_q;
            else if (hit_pd_set || hit_pd_clr)
                bus_rdata[NUM_IRQ-1:0] = pend_q;
            else if (hit_lvl) begin
                for (int k = 0; k < 4; k++)
                    bus_rdata[8*k+7 -: PRIO_BITS] = lvl_q[4*int'(lvl_idx) + k];
            end
        end
    end

    assign en_o   = en_q;
    assign pend_o = pend_q;

    AST_SUBWORD_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_size != SZ_WORD) |=> ($stable(en_q) && $stable(lvl_o))); // R5
    AST_WORD_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_size == SZ_WORD) |-> !bus_err); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !set_vec[ack_id_i]) |=> !pend_q[$past(ack_id_i)]); // R9

endmodule

// File: rtl/irq_arbiter.sv
// Combinational selector of the most urgent active interrupt line.
// A smaller level value is more urgent; within a level the lowest line number
// wins. Assumes the active vector already combines pending with enable.
module irq_arbiter #(
    parameter int NUM_IRQ    = 32,
    parameter int PRIO_BITS  = 2,
    localparam int ID_W      = $clog2(NUM_IRQ),
    localparam int NUM_LEVEL = 1 << PRIO_BITS
) (
    input  logic [NUM_IRQ-1:0]           active_i,
    input  logic [NUM_IRQ*PRIO_BITS-1:0] lvl_i,
    output logic                         win_valid_o,
    output logic [ID_W-1:0]              win_id_o
);

    logic [NUM_IRQ-1:0] lvl_mask [NUM_LEVEL];

    // Split the active lines into one mask per level.
    for (genvar l = 0; l < NUM_LEVEL; l++) begin : g_mask
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
            assign lvl_mask[l][i] = active_i[i]
                                    && (lvl_i[i*PRIO_BITS +: PRIO_BITS] == PRIO_BITS'(l));
        end
    end

    // Take the first non-empty level, then its lowest set bit.
    always_comb begin
        win_valid_o = 1'b0;
        win_id_o    = '0;
        for (int l = 0; l < NUM_LEVEL; l++) begin
            if (!win_valid_o && (|lvl_mask[l])) begin
                win_valid_o = 1'b1;
                for (int i = NUM_IRQ - 1; i >= 0; i--) begin
                    if (lvl_mask[l][i]) win_id_o = ID_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
// Top of the prioritized interrupt controller.
// Ties the edge detector, register file and arbiter together and registers
// the selected line onto the core-facing outputs. Assumes a word-wide
// register bus with a combinational read path.
module irq_prio_ctrl #(
    parameter int NUM_IRQ   = 32,
    parameter int PRIO_BITS = 2,
    parameter int ADDR_W    = 12,
    localparam int ID_W     = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [1:0]         bus_size,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_err,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               core_ack,
    input  logic [ID_W-1:0]    core_ack_id,
    output logic               irq_valid,
    output logic [ID_W-1:0]    irq_id
);

    logic [NUM_IRQ-1:0]           rise;
    logic [NUM_IRQ-1:0]           en, pend, active;
    logic [NUM_IRQ*PRIO_BITS-1:0] lvl;
    logic                         win_valid;
    logic [ID_W-1:0]              win_id;

    irq_edge_det #(.NUM_IRQ(NUM_IRQ)) i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (irq_in),
        .rise_o  (rise)
    );

    irq_reg_file #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .rise_i    (rise),
        .ack_i     (core_ack),
        .ack_id_i  (core_ack_id),
        .en_o      (en),
        .pend_o    (pend),
        .lvl_o     (lvl)
    );

    assign active = pend & en;

    irq_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) i_arb (
        .active_i    (active),
        .lvl_i       (lvl),
        .win_valid_o (win_valid),
        .win_id_o    (win_id)
    );

    // Register the selection toward the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_id    <= '0;
        end else begin
            irq_valid <= win_valid;
            irq_id    <= win_id;
        end
    end

    AST_VALID_ID_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (($past(active) & (NUM_IRQ'(1) << irq_id)) != '0)); // R7
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) == '0) |-> !irq_valid); // R8

endmodule

// File: tb/test_irq_prio_ctrl.sv
// Self-checking bench: a vector table for register semantics, then
// directed tests for reset, size errors, edges, arbitration and acknowledge.
module test_irq_prio_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [1:0]  bus_size = 2'b10;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [31:0] irq_in = '0;
    logic        core_ack = 1'b0;
    logic [4:0]  core_ack_id = '0;
    logic        irq_valid;
    logic [4:0]  irq_id;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_size, .bus_wdata,
        .bus_rdata, .bus_err, .irq_in, .core_ack, .core_ack_id, .irq_valid, .irq_id
    );

    // Vector: {write, req tag, addr, wdata, expected read}
    localparam int NV = 22;
    localparam logic [80:0] VEC [NV] = '{
        {1'b1, 4'd2,  12'h100, 32'h0000_00F0, 32'h0},            // R2 set
        {1'b0, 4'd2,  12'h100, 32'h0,         32'h0000_00F0},
        {1'b0, 4'd2,  12'h180, 32'h0,         32'h0000_00F0},    // R2 read via clear addr
        {1'b1, 4'd2,  12'h180, 32'h0000_0030, 32'h0},
        {1'b0, 4'd2,  12'h100, 32'h0,         32'h0000_00C0},
        {1'b1, 4'd2,  12'h100, 32'h0,         32'h0},            // R2 zero has no effect
        {1'b0, 4'd2,  12'h100, 32'h0,         32'h0000_00C0},
        {1'b1, 4'd2,  12'h180, 32'h0000_00C0, 32'h0},
        {1'b0, 4'd2,  12'h100, 32'h0,         32'h0},
        {1'b1, 4'd3,  12'h200, 32'h8000_0001, 32'h0},            // R3
        {1'b0, 4'd3,  12'h280, 32'h0,         32'h8000_0001},
        {1'b1, 4'd3,  12'h280, 32'h0000_0001, 32'h0},
        {1'b0, 4'd3,  12'h200, 32'h0,         32'h8000_0000},
        {1'b1, 4'd3,  12'h280, 32'h8000_0000, 32'h0},
        {1'b0, 4'd3,  12'h200, 32'h0,         32'h0},
        {1'b1, 4'd4,  12'h400, 32'hFFFF_FFFF, 32'h0},            // R4 lanes
        {1'b0, 4'd4,  12'h400, 32'h0,         32'hC0C0_C0C0},
        {1'b1, 4'd4,  12'h41C, 32'h1234_5678, 32'h0},
        {1'b0, 4'd4,  12'h41C, 32'h0,         32'h0000_4040},
        {1'b1, 4'd10, 12'h300, 32'hFFFF_FFFF, 32'h0},            // R10 unmapped
        {1'b0, 4'd10, 12'h300, 32'h0,         32'h0},
        {1'b0, 4'd4,  12'h404, 32'h0,         32'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_size = 2'b10; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_size = 2'b10; bus_addr = a;
        #1 check(req, bus_rdata, exp);
    endtask

    task automatic step();
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic chk_irq(input string req, input logic v, input logic [4:0] id);
        check(req, {26'b0, irq_valid, v ? irq_id : 5'd0}, {26'b0, v, id});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        #1 chk_irq("R1", 1'b0, 5'd0);
        rd("R1", 12'h100, 32'h0);
        rd("R1", 12'h200, 32'h0);
        rd("R1", 12'h400, 32'h0);
        rd("R1", 12'h41C, 32'h0);

        // Register semantics table
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][80]) wr(VEC[v][75:64], VEC[v][63:32]);
            else rd($sformatf("R%0d", VEC[v][79:76]), VEC[v][75:64], VEC[v][31:0]);
        end
        wr(12'h400, 32'h0);
        wr(12'h41C, 32'h0);

        // R5 sub-word accesses
        wr(12'h100, 32'h3);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_size = 2'b00; bus_addr = 12'h100; bus_wdata = 32'hFF;
        #1 check("R5 err", {31'b0, bus_err}, 32'h1);
        @(negedge clk);
        bus_size = 2'b01; bus_addr = 12'h404; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_wr = 1'b0; bus_size = 2'b00; bus_addr = 12'h100;
        #1 check("R5 rd zero", bus_rdata, 32'h0);
        rd("R5 en kept", 12'h100, 32'h3);
        rd("R5 lvl kept", 12'h404, 32'h0);
        #1 check("R5 word no err", {31'b0, bus_err}, 32'h0);
        wr(12'h180, 32'hFFFF_FFFF);

        // R6 rising edge on a line
        @(negedge clk) irq_in[7] = 1'b1;
        rd("R6 edge", 12'h200, 32'h80);
        wr(12'h280, 32'h80);
        step(); step();
        rd("R6 held high", 12'h200, 32'h0);
        @(negedge clk) irq_in[7] = 1'b0;
        @(negedge clk) irq_in[7] = 1'b1;
        rd("R6 re-edge", 12'h200, 32'h80);
        irq_in[7] = 1'b0;
        wr(12'h280, 32'h80);

        // R7/R8 arbitration: lines 5,9 at level 1, line 3 at level 3, line 20 at level 0
        wr(12'h404, 32'h0000_4000);
        wr(12'h408, 32'h0000_4000);
        wr(12'h400, 32'hC000_0000);
        wr(12'h100, 32'h0010_0228);
        wr(12'h200, 32'h0000_0208);
        chk_irq("R8 lag", 1'b0, 5'd0);
        step(); chk_irq("R7 level", 1'b1, 5'd9);
        wr(12'h200, 32'h0000_0020);
        chk_irq("R8 lag", 1'b1, 5'd9);
        step(); chk_irq("R7 tie", 1'b1, 5'd5);
        wr(12'h200, 32'h0010_0000);
        step(); chk_irq("R7 level0", 1'b1, 5'd20);

        // R9 acknowledge clears pending
        @(negedge clk); core_ack = 1'b1; core_ack_id = 5'd20;
        @(negedge clk); core_ack = 1'b0;
        chk_irq("R8 lag after ack", 1'b1, 5'd20);
        step(); chk_irq("R9 next", 1'b1, 5'd5);
        rd("R9 pend", 12'h200, 32'h0000_0228);

        wr(12'h180, 32'h0000_0020);
        step(); chk_irq("R7 disabled", 1'b1, 5'd9);
        wr(12'h408, 32'h0000_C000);
        step(); chk_irq("R7 tie level3", 1'b1, 5'd3);

        // R9 set wins over acknowledge
        @(negedge clk);
        core_ack = 1'b1; core_ack_id = 5'd3;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_size = 2'b10; bus_addr = 12'h200; bus_wdata = 32'h8;
        @(negedge clk);
        core_ack = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd("R9 set wins", 12'h200, 32'h0000_0228);

        // R8 idle when nothing is pending
        wr(12'h280, 32'hFFFF_FFFF);
        step(); chk_irq("R8 idle", 1'b0, 5'd0);

        finish_run();
    end

endmodule